// File: doc/BRIEF.md
# Fifteen-Level Staircase Inverter Gate Sequencer

This block drives the ten power-switch gates of a fifteen-level asymmetric inverter. The inverter stacks three DC sources weighted 1, 2 and 4. A six-switch selector stage picks the magnitude, and a four-switch bridge sets the polarity. A phase accumulator advances by a programmable increment on every clock, and one full turn of the accumulator is one fundamental period. Seven programmable first-quarter switching angles are folded into the other three quarters. The block counts how many angles the folded phase has passed, and that count gives a signed level from -7 to +7.

The signed level goes through a fixed switching table to the gate vector. Positive levels turn on one diagonal of the bridge and negative levels the other. A zero level uses either both upper or both lower bridge switches, and the block alternates between those two pairs on successive zero intervals. Angle values are captured only when the accumulator wraps, so a period in progress never changes shape. Deassert the enable to stop the output: all gates go low and the phase restarts from zero.

Top module: `ml_stair_seq`

## Requirements
- R1: While reset is high or `run_en_i` is low, every gate bit and `level_o` are 0 one clock later. The accumulator is cleared, so the first enabled clock evaluates phase 0.
- R2: While enabled, the 32-bit phase advances by `phase_inc_i` each clock, modulo 2^32. A full turn (2^32) is one fundamental period.
- R3: For a phase p below 2^30 (first quarter), the level magnitude equals the number of angles a with p >= a, and the level is positive.
- R4: The second quarter (2^30 <= p < 2^31) gives +count(2^31-p > a). The third quarter gives -count(p-2^31 >= a). The fourth quarter gives -count(2^32-p > a).
- R5: Bridge bits are gate bit 0 (left upper), bit 1 (left lower), bit 2 (right upper) and bit 3 (right lower). A positive level sets bits 0 and 3, and a negative level sets bits 1 and 2.
- R6: Selector bits are 4,5,6 (coarse c0,c1,c2) and 7,8,9 (fine f0,f1,f2). The magnitudes map as follows: 1 sets f2; 2 sets c2,f0; 3 sets c2,f1; 4 sets c0,f0; 5 sets c0,f1; 6 sets c1,f0; 7 sets c1,f1.
- R7: At level 0 while enabled, bits 4..9 are low and one bridge pair is on: upper (bits 0,2) or lower (bits 1,3). The upper pair is used after reset or enable, and the pair swaps each time the level goes from nonzero to zero.
- R8: No more than four gate bits are ever high, and the two switches of one bridge leg (bits 0/1, bits 2/3) are never on together.
- R9: The angle inputs are captured on the clock where the accumulator carries past 2^32, and on every clock while disabled. Angle changes at other times have no effect until the next wrap.
- R10: `gate_o` and `level_o` are registered. They reflect the phase and angle copies held in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| run_en_i | input | 1 | Run enable; low forces gates off and clears phase |
| phase_inc_i | input | 32 | Phase step per clock (2^32 = one period) |
| angle_i | input | 224 | Seven angles, 32 bits each, angle k at bits [32k+31:32k] |
| gate_o | output | 10 | Gate enables (bit map in R5, R6) |
| level_o | output | 4 | Current signed output level, two's complement |

## Verification
The assertions assume that reset is applied at start-up before the enable is used. For an orderly staircase they also assume ascending angles below a quarter turn. The gate invariants themselves (at most four switches on, legs exclusive, the fixed zero pattern) hold for any angles and any increment. The stimulus mostly uses ascending in-range angles. It also covers angles above a quarter turn, repeated angles and increments larger than a quarter turn, and the reference model computes the count rule for every one of these. Angle-exact phase landings check the direction of the comparison at each quarter boundary.

// File: rtl/ml_stair_pkg.sv
package ml_stair_pkg;
    localparam int STEPS  = 7;
    localparam int MAG_W  = $clog2(STEPS + 1);
    localparam int LVL_W  = MAG_W + 1;
    localparam int GATE_N = 10;

    typedef logic signed [LVL_W-1:0] lvl_t;
    typedef logic [GATE_N-1:0]       gate_t;

    // bridge legs
    localparam int G_HA = 0;
    localparam int G_LA = 1;
    localparam int G_HB = 2;
    localparam int G_LB = 3;
    // selector stage
    localparam int G_C0 = 4;
    localparam int G_C1 = 5;
    localparam int G_C2 = 6;
    localparam int G_F0 = 7;
    localparam int G_F1 = 8;
    localparam int G_F2 = 9;
endpackage

// File: rtl/ml_phase_acc.sv
module ml_phase_acc #(
    parameter int PW = 32
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    input  logic [PW-1:0] inc_i,
    output logic [PW-1:0] phase_o,
    output logic          wrap_o
);
    typedef struct packed {
        logic [PW-1:0] phase;
    } acc_s;

    acc_s        st_d, st_q;
    logic [PW:0] sum_w;

    always_comb begin
        sum_w  = {1'b0, st_q.phase} + {1'b0, inc_i};
        st_d   = st_q;
        wrap_o = 1'b0;
        if (!en_i) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = sum_w[PW-1:0];
            wrap_o     = sum_w[PW];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign phase_o = st_q.phase;

    assert_phase_idle_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (st_q.phase == '0));

    assert_phase_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> (st_q.phase == PW'($past(st_q.phase) + $past(inc_i))));
endmodule

// File: rtl/ml_level_dec.sv
module ml_level_dec
    import ml_stair_pkg::*;
#(
    parameter int PW = 32
) (
    input  logic [PW-1:0]       phase_i,
    input  logic [STEPS*PW-1:0] ang_i,
    output lvl_t                lvl_o
);
    localparam int FW = PW - 2;

    logic [FW-1:0]    fold_w;
    logic [STEPS-1:0] hit_w;
    logic [MAG_W-1:0] mag_w;
    logic [LVL_W-1:0] pos_w;

    // fold the quarter: odd quarters run backwards, biased by one so
    // that ">=" here means "strictly past" the mirrored instant
    assign fold_w = phase_i[PW-2] ? ~phase_i[FW-1:0] : phase_i[FW-1:0];

    generate
        for (genvar k = 0; k < STEPS; k++) begin : g_cmp
            assign hit_w[k] = ({2'b00, fold_w} >= ang_i[k*PW +: PW]);
        end
    endgenerate

    always_comb begin
        mag_w = '0;
        for (int k = 0; k < STEPS; k++) begin
            mag_w = mag_w + MAG_W'(hit_w[k]);
        end
    end

    always_comb begin
        pos_w = {1'b0, mag_w};
        if (phase_i[PW-1]) lvl_o = lvl_t'(LVL_W'(0) - pos_w);
        else               lvl_o = lvl_t'(pos_w);
    end
endmodule

// File: rtl/ml_gate_map.sv
module ml_gate_map
    import ml_stair_pkg::*;
(
    input  lvl_t  lvl_i,
    input  logic  zsel_i,
    output gate_t gate_o
);
    logic             neg_w;
    logic [LVL_W-1:0] abs_w;
    logic [MAG_W-1:0] mag_w;

    always_comb begin
        neg_w  = lvl_i[LVL_W-1];
        abs_w  = neg_w ? (LVL_W'(0) - lvl_i) : lvl_i;
        mag_w  = abs_w[MAG_W-1:0];
        gate_o = '0;
        unique case (mag_w)
            3'd1: gate_o[G_F2] = 1'b1;
            3'd2: begin gate_o[G_C2] = 1'b1; gate_o[G_F0] = 1'b1; end
            3'd3: begin gate_o[G_C2] = 1'b1; gate_o[G_F1] = 1'b1; end
            3'd4: begin gate_o[G_C0] = 1'b1; gate_o[G_F0] = 1'b1; end
            3'd5: begin gate_o[G_C0] = 1'b1; gate_o[G_F1] = 1'b1; end
            3'd6: begin gate_o[G_C1] = 1'b1; gate_o[G_F0] = 1'b1; end
            3'd7: begin gate_o[G_C1] = 1'b1; gate_o[G_F1] = 1'b1; end
            default: ;
        endcase
        if (mag_w == '0) begin
            if (zsel_i) begin gate_o[G_LA] = 1'b1; gate_o[G_LB] = 1'b1; end
            else        begin gate_o[G_HA] = 1'b1; gate_o[G_HB] = 1'b1; end
        end else if (neg_w) begin
            gate_o[G_LA] = 1'b1; gate_o[G_HB] = 1'b1;
        end else begin
            gate_o[G_HA] = 1'b1; gate_o[G_LB] = 1'b1;
        end
    end
endmodule

// File: rtl/ml_stair_seq.sv
module ml_stair_seq
    import ml_stair_pkg::*;
#(
    parameter int PW = 32
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                run_en_i,
    input  logic [PW-1:0]       phase_inc_i,
    input  logic [STEPS*PW-1:0] angle_i,
    output logic [GATE_N-1:0]   gate_o,
    output logic [LVL_W-1:0]    level_o
);
    typedef struct packed {
        logic [STEPS*PW-1:0] shadow;
        lvl_t                lvl;
        logic                zsel;
        gate_t               gate;
    } seq_s;

    seq_s          st_d, st_q;
    logic [PW-1:0] phase_w;
    logic          wrap_w;
    lvl_t          dec_lvl_w;
    lvl_t          lvl_nx;
    logic          zsel_nx;
    gate_t         map_gate_w;

    ml_phase_acc #(.PW(PW)) u_acc (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (run_en_i),
        .inc_i   (phase_inc_i),
        .phase_o (phase_w),
        .wrap_o  (wrap_w)
    );

    ml_level_dec #(.PW(PW)) u_dec (
        .phase_i (phase_w),
        .ang_i   (st_q.shadow),
        .lvl_o   (dec_lvl_w)
    );

    always_comb begin
        lvl_nx  = run_en_i ? dec_lvl_w : lvl_t'(0);
        zsel_nx = st_q.zsel;
        if (!run_en_i)
            zsel_nx = 1'b0;
        else if (lvl_nx == lvl_t'(0) && st_q.lvl != lvl_t'(0))
            zsel_nx = ~st_q.zsel;
    end

    ml_gate_map u_map (
        .lvl_i  (lvl_nx),
        .zsel_i (zsel_nx),
        .gate_o (map_gate_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.lvl  = lvl_nx;
        st_d.zsel = zsel_nx;
        st_d.gate = run_en_i ? map_gate_w : '0;
        if (!run_en_i || wrap_w) st_d.shadow = angle_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign gate_o  = st_q.gate;
    assign level_o = st_q.lvl;

    assert_gates_idle_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_en_i |=> (gate_o == '0 && level_o == '0));

    assert_level_range_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.lvl != lvl_t'(-8));

    assert_pos_bridge_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.lvl > lvl_t'(0)) |-> (st_q.gate[3:0] == 4'b1001));

    assert_neg_bridge_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.lvl < lvl_t'(0)) |-> (st_q.gate[3:0] == 4'b0110));

    assert_zero_pattern_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.lvl == lvl_t'(0) && st_q.gate != '0) |->
            (st_q.gate[9:4] == '0 &&
             (st_q.gate[3:0] == 4'b0101 || st_q.gate[3:0] == 4'b1010)));

    assert_zero_swap_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_en_i && st_q.lvl != lvl_t'(0) && dec_lvl_w == lvl_t'(0))
            |=> (st_q.zsel != $past(st_q.zsel)));

    assert_gate_cap_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(gate_o) <= 4);

    assert_leg_excl_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !(gate_o[G_HA] && gate_o[G_LA]) && !(gate_o[G_HB] && gate_o[G_LB]));

    assert_angle_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_en_i && !wrap_w) |=> $stable(st_q.shadow));
endmodule

// File: tb/sim_ml_stair_seq.sv
module sim_ml_stair_seq;
    localparam longint QTR  = 64'd1 << 30;
    localparam longint HALF = 64'd1 << 31;
    localparam longint FULL = 64'd1 << 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [31:0] inc = '0;
    logic [31:0] ang [7];
    logic [223:0] ang_bus;
    logic [9:0]  gate_o;
    logic signed [3:0] level_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 7; k++) ang_bus[k*32 +: 32] = ang[k];
    end

    ml_stair_seq u0 (
        .clk_i       (clk),
        .rst_i       (rst),
        .run_en_i    (en),
        .phase_inc_i (inc),
        .angle_i     (ang_bus),
        .gate_o      (gate_o),
        .level_o     (level_o)
    );

    // ---------------- behavioural reference ----------------
    longint m_phase = 0;
    longint m_sh [7];
    int     m_lvl  = 0;
    bit     m_zsel = 0;
    bit     m_idle = 1;
    logic [9:0] m_gate = '0;

    function automatic int ref_level(longint p, longint sh [7]);
        int c = 0;
        if (p < QTR) begin
            for (int k = 0; k < 7; k++) if (p >= sh[k]) c++;
            return c;
        end else if (p < HALF) begin
            for (int k = 0; k < 7; k++) if (HALF - p > sh[k]) c++;
            return c;
        end else if (p < HALF + QTR) begin
            for (int k = 0; k < 7; k++) if (p - HALF >= sh[k]) c++;
            return -c;
        end
        for (int k = 0; k < 7; k++) if (FULL - p > sh[k]) c++;
        return -c;
    endfunction

    function automatic logic [9:0] ref_gate(int l, bit z);
        logic [9:0] g = '0;
        int m = (l < 0) ? -l : l;
        case (m)
            1: g[9] = 1;
            2: begin g[6] = 1; g[7] = 1; end
            3: begin g[6] = 1; g[8] = 1; end
            4: begin g[4] = 1; g[7] = 1; end
            5: begin g[4] = 1; g[8] = 1; end
            6: begin g[5] = 1; g[7] = 1; end
            7: begin g[5] = 1; g[8] = 1; end
            default: ;
        endcase
        if (l > 0)      begin g[0] = 1; g[3] = 1; end
        else if (l < 0) begin g[1] = 1; g[2] = 1; end
        else if (z)     begin g[1] = 1; g[3] = 1; end
        else            begin g[0] = 1; g[2] = 1; end
        return g;
    endfunction

    always @(posedge clk) begin
        int  nl;
        bit  nz;
        longint s;
        if (rst) begin
            m_phase = 0; m_lvl = 0; m_zsel = 0; m_gate = '0; m_idle = 1;
            for (int k = 0; k < 7; k++) m_sh[k] = 0;
        end else if (!en) begin
            m_phase = 0; m_lvl = 0; m_zsel = 0; m_gate = '0; m_idle = 1;
            for (int k = 0; k < 7; k++) m_sh[k] = longint'(ang[k]);
        end else begin
            nl = ref_level(m_phase, m_sh);
            nz = (nl == 0 && m_lvl != 0) ? ~m_zsel : m_zsel;
            s  = m_phase + longint'(inc);
            if (s >= FULL) begin
                s = s - FULL;
                for (int k = 0; k < 7; k++) m_sh[k] = longint'(ang[k]);
            end
            m_phase = s; m_lvl = nl; m_zsel = nz; m_idle = 0;
            m_gate  = ref_gate(nl, nz);
        end
    end

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            // level: R3/R4, with phase stepping R2, angle capture R9, one-clock latency R10
            chk(int'(level_o) == m_lvl, "R3/R4 level (R2 R9 R10)", int'(level_o), m_lvl);
            chk(gate_o[3:0] == m_gate[3:0], (m_lvl == 0) ? "R7 bridge" : "R5 bridge",
                gate_o[3:0], m_gate[3:0]);
            chk(gate_o[9:4] == m_gate[9:4], (m_lvl == 0) ? "R7 selector" : "R6 selector",
                gate_o[9:4], m_gate[9:4]);
            chk($countones(gate_o) <= 4 && !(gate_o[0] && gate_o[1]) && !(gate_o[2] && gate_o[3]),
                "R8 switch cap", $countones(gate_o), 4);
            if (m_idle) chk(gate_o == '0 && level_o == '0, "R1 idle", gate_o, 0);
        end
    end

    function automatic logic [31:0] deg(real d);
        return 32'(longint'(d / 360.0 * 4294967296.0));
    endfunction

    task automatic set_default_angles();
        ang[0] = deg(4.096); ang[1] = deg(12.37); ang[2] = deg(20.92);
        ang[3] = deg(30.0);  ang[4] = deg(40.0);  ang[5] = deg(51.78);
        ang[6] = deg(68.21);
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        set_default_angles();
        run(5);
        // R1: reset state
        chk(gate_o == '0, "R1 reset gates", gate_o, 0);
        chk(level_o == '0, "R1 reset level", level_o, 0);
        rst = 1'b0;
        run(2);

        // nominal staircase, 800 clocks per period
        inc = 32'd5368709;
        en  = 1'b1;
        run(2500);

        // R9: new angles mid-period take effect only at the next wrap
        for (int k = 0; k < 7; k++) ang[k] = 32'((k + 1) * 134217728 - 12345);
        run(1700);

        // R1: disable, then restart from phase zero
        en = 1'b0;
        run(20);
        set_default_angles();
        en = 1'b1;
        run(900);

        // angle-exact landings at every quarter boundary (R3, R4)
        en = 1'b0;
        for (int k = 0; k < 7; k++) ang[k] = 32'((k + 1) * 20 * 4194304);
        inc = 32'd4194304;
        run(3);
        en = 1'b1;
        run(2100);

        // coarse steps larger than a quarter turn
        inc = 32'h3000_0001;
        run(300);
        inc = 32'hA123_4567;
        run(300);

        // unreachable and repeated angles
        ang[6] = 32'h5000_0000;
        ang[5] = 32'hFFFF_FFFF;
        ang[3] = ang[2];
        inc = 32'd7000001;
        run(1500);

        // frozen phase
        inc = '0;
        run(50);

        // reset while running
        inc = 32'd9999991;
        rst = 1'b1;
        run(3);
        rst = 1'b0;
        run(1000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule